// File: doc/BRIEF.md
# Packed-Symbol Error Correction Applier

This block sits behind a Reed-Solomon decoder for a flash page. The decoder hands it a short list of error locations, each a symbol index, and a 12-bit error value for each location. The page lives in a byte-wide single-port buffer: 2048 data bytes, then the spare bytes. The 12-bit code symbols are packed back to back across that buffer, so one symbol covers one and a half bytes. Even and odd symbols start on opposite nibble boundaries.

For each error, the block finds the one or two buffer bytes that the symbol covers and the nibble alignment within them. It then patches each byte with a read, XOR, write sequence on the buffer port. Symbol 0 is short: it carries only eight bits, all in data byte 0. Symbol 1365 straddles the last data byte and the first spare byte. Higher symbols fall in the spare area, and the same packing rule continues there.

Before it writes anything, the block screens the whole list. If any entry cannot be applied, the page is declared uncorrectable: the buffer is left untouched and a fail flag is raised. Otherwise a done strobe reports how many errors were applied.

Top module: `symfix_apply`

## Requirements
- R1: Symbol 0 patches only buffer byte 0, with the low eight bits of its error value, in one read/write pair.
- R2: If symbol 0 is listed with any of error-value bits 11:8 set, the job fails and no buffer write takes place.
- R3: An odd symbol p patches byte floor(3p/2) with error bits 11:4. It then patches byte floor(3p/2)+1 with error bits 3:0 placed in bits 7:4 of the XOR mask.
- R4: An even nonzero symbol p patches byte 3p/2-1 with error bits 11:8 placed in bits 3:0 of the XOR mask. It then patches byte 3p/2 with error bits 7:0.
- R5: Symbol 1365 patches data byte 2047 with error bits 11:4. It patches buffer byte 2048 (the first spare byte) with error bits 3:0 in its high nibble.
- R6: Symbols 1366 through 1374 follow the odd/even rule of R3 and R4 on the same continuous byte numbering, so they land in the spare bytes (buffer address 2048 and up).
- R7: A listed symbol index above 1374 makes the job fail with no buffer write.
- R8: A single unusable entry among the first n fails the whole job, even when earlier entries are valid. List entries at positions n and above are ignored, whatever they contain.
- R9: An error count above four makes the job fail with no buffer write.
- R10: Each byte patch is a read cycle followed at once by a write cycle to the same address, with write data equal to the returned byte XOR the mask. Errors are handled in list order, and the lower address of a pair comes first. A byte shared by two errors therefore accumulates both patches.
- R11: After reset, done, fail and count are low or zero, and no buffer access is made. On success, done pulses for one cycle in the cycle after the last write, with fail low and count equal to n. With n = 0, done comes two cycles after start.
- R12: A failing job raises done together with fail, with count 0, two cycles after start.
- R13: A start pulse while a job is running is ignored and does not change the ongoing access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a job; the list inputs are captured in the same cycle |
| err_cnt_i | input | 4 | Number of valid list entries |
| err_pos_i | input | 48 | Four 12-bit symbol indices; entry i is in bits 12i+11:12i |
| err_pat_i | input | 48 | Four 12-bit error values; entry i is in bits 12i+11:12i |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after a read |
| buf_addr_o | output | 12 | Buffer byte address |
| buf_rd_o | output | 1 | Buffer read enable |
| buf_wr_o | output | 1 | Buffer write enable |
| buf_wdata_o | output | 8 | Buffer write data |
| done_o | output | 1 | One-cycle end-of-job strobe |
| fail_o | output | 1 | Last job was uncorrectable; held until the next job ends |
| count_o | output | 4 | Errors applied by the last job; held until the next job ends |

## Verification
Single-error jobs cover symbol 0, an odd index and an even index in the data area, the boundary symbol 1365, and both parities in the spare area. Each one separates the nibble placement and address offset of one branch of the mapping from the others. A four-error job uses two symbols that share a byte, which shows that patches accumulate in list order rather than overwrite one another. Failing jobs cover an over-wide symbol 0, an index past 1374, a bad entry hidden behind a good one, and a count of five. Each must leave the buffer image identical to the bench copy. A job whose unused list slots hold garbage, an empty job, and a start pulse injected mid-job check that only the first n entries and the first start count.

// File: rtl/symfix_pkg.sv
package symfix_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_RD,
      ST_WR,
      ST_DONE
   } seq_state_t;

endpackage

// File: rtl/symfix_map.sv
module symfix_map #(
   parameter int POS_W   = 12,
   parameter int SYM_W   = 12,
   parameter int ADDR_W  = 12,
   parameter int MAX_SYM = 1374
) (
   input  logic [POS_W-1:0]  pos_i,
   input  logic [SYM_W-1:0]  pat_i,
   output logic [ADDR_W-1:0] addr0_o,
   output logic [7:0]        mask0_o,
   output logic [ADDR_W-1:0] addr1_o,
   output logic [7:0]        mask1_o,
   output logic              pair_o,
   output logic              ok_o
);

   localparam logic [POS_W-1:0] LIMIT = POS_W'(MAX_SYM);

   logic [POS_W+1:0] trip;
   logic [POS_W:0]   half;
   logic [POS_W:0]   half_m1;
   logic             is_zero;

   // Byte offset of a symbol is floor(3p/2); spare bytes continue the numbering.
   assign trip    = {2'b00, pos_i} + {1'b0, pos_i, 1'b0};
   assign half    = (POS_W+1)'(trip >> 1);
   assign half_m1 = half - {{POS_W{1'b0}}, 1'b1};
   assign is_zero = (pos_i == '0);

   always_comb begin
      addr0_o = '0;
      mask0_o = pat_i[7:0];
      addr1_o = '0;
      mask1_o = '0;
      pair_o  = 1'b0;
      if (!is_zero) begin
         pair_o = 1'b1;
         if (pos_i[0]) begin
            addr0_o = ADDR_W'(half);
            mask0_o = pat_i[SYM_W-1 -: 8];
            addr1_o = ADDR_W'(half) + ADDR_W'(1);
            mask1_o = {pat_i[3:0], 4'h0};
         end else begin
            addr0_o = ADDR_W'(half_m1);
            mask0_o = {4'h0, pat_i[SYM_W-1 -: 4]};
            addr1_o = ADDR_W'(half);
            mask1_o = pat_i[7:0];
         end
      end
   end

   assign ok_o = (pos_i <= LIMIT) && (!is_zero || (pat_i[SYM_W-1:8] == '0));

endmodule

// File: rtl/symfix_screen.sv
module symfix_screen #(
   parameter int MAX_ERR = 4,
   parameter int CNT_W   = 4
) (
   input  logic [MAX_ERR-1:0] ok_i,
   input  logic [CNT_W-1:0]   cnt_i,
   output logic               bad_o
);

   logic [MAX_ERR-1:0] active;

   for (genvar i = 0; i < MAX_ERR; i++) begin : g_act
      assign active[i] = (cnt_i > CNT_W'(i));
   end

   assign bad_o = (cnt_i > CNT_W'(MAX_ERR)) || (|(active & ~ok_i));

endmodule

// File: rtl/symfix_seq.sv
module symfix_seq
   import symfix_pkg::*;
#(
   parameter int MAX_ERR = 4,
   parameter int POS_W   = 12,
   parameter int SYM_W   = 12,
   parameter int ADDR_W  = 12,
   parameter int CNT_W   = 4,
   parameter int IDX_W   = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      start_i,
   input  logic [CNT_W-1:0]          cnt_i,
   input  logic [MAX_ERR*POS_W-1:0]  pos_i,
   input  logic [MAX_ERR*SYM_W-1:0]  pat_i,
   output logic [MAX_ERR*POS_W-1:0]  lat_pos_o,
   output logic [MAX_ERR*SYM_W-1:0]  lat_pat_o,
   output logic [CNT_W-1:0]          lat_cnt_o,
   input  logic [MAX_ERR*ADDR_W-1:0] m_addr0_i,
   input  logic [MAX_ERR*8-1:0]      m_mask0_i,
   input  logic [MAX_ERR*ADDR_W-1:0] m_addr1_i,
   input  logic [MAX_ERR*8-1:0]      m_mask1_i,
   input  logic [MAX_ERR-1:0]        m_pair_i,
   input  logic                      bad_i,
   input  logic [7:0]                rdata_i,
   output logic [ADDR_W-1:0]         buf_addr_o,
   output logic                      rd_o,
   output logic                      wr_o,
   output logic [7:0]                wdata_o,
   output logic                      done_o,
   output logic                      fail_o,
   output logic [CNT_W-1:0]          count_o
);

   seq_state_t       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             part_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx_ext;
   logic             last_err;
   logic             cur_pair;
   logic [7:0]       cur_mask;

   assign lat_cnt_o = cnt_q;
   assign idx_ext   = CNT_W'(idx_q);
   assign last_err  = ((idx_ext + CNT_W'(1)) == cnt_q);
   assign cur_pair  = m_pair_i[idx_q];
   assign cur_mask  = part_q ? m_mask1_i[idx_q*8 +: 8] : m_mask0_i[idx_q*8 +: 8];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         part_q    <= 1'b0;
         cnt_q     <= '0;
         lat_pos_o <= '0;
         lat_pat_o <= '0;
         fail_o    <= 1'b0;
         count_o   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  lat_pos_o <= pos_i;
                  lat_pat_o <= pat_i;
                  cnt_q     <= cnt_i;
                  state_q   <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               idx_q  <= '0;
               part_q <= 1'b0;
               if (bad_i) begin
                  fail_o  <= 1'b1;
                  count_o <= '0;
                  state_q <= ST_DONE;
               end else if (cnt_q == '0) begin
                  fail_o  <= 1'b0;
                  count_o <= '0;
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_RD;
               end
            end
            ST_RD: state_q <= ST_WR;
            ST_WR: begin
               if (!part_q && cur_pair) begin
                  part_q  <= 1'b1;
                  state_q <= ST_RD;
               end else if (last_err) begin
                  fail_o  <= 1'b0;
                  count_o <= cnt_q;
                  state_q <= ST_DONE;
               end else begin
                  idx_q   <= idx_q + IDX_W'(1);
                  part_q  <= 1'b0;
                  state_q <= ST_RD;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_o       = (state_q == ST_RD);
   assign wr_o       = (state_q == ST_WR);
   assign done_o     = (state_q == ST_DONE);
   assign buf_addr_o = part_q ? m_addr1_i[idx_q*ADDR_W +: ADDR_W]
                              : m_addr0_i[idx_q*ADDR_W +: ADDR_W];
   assign wdata_o    = rdata_i ^ cur_mask;

   // R10: a read is always followed by its write to the same byte
   a_r10_read_then_write: assert property (@(posedge clk) disable iff (rst)
      rd_o |=> (wr_o && $stable(buf_addr_o)));

   // R10: no write without the read in the cycle before
   a_r10_write_after_read: assert property (@(posedge clk) disable iff (rst)
      wr_o |-> $past(rd_o));

   // R11: done lasts exactly one cycle
   a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   // R12: a failing job ends without having written
   a_r12_fail_quiet: assert property (@(posedge clk) disable iff (rst)
      (done_o && fail_o) |-> !$past(wr_o));

endmodule

// File: rtl/symfix_apply.sv
module symfix_apply #(
   parameter int DATA_BYTES  = 2048,
   parameter int SPARE_BYTES = 64,
   parameter int SYM_W       = 12,
   parameter int MAX_ERR     = 4,
   parameter int MAX_SYM     = 1374,
   localparam int BUF_BYTES  = DATA_BYTES + SPARE_BYTES,
   localparam int ADDR_W     = $clog2(BUF_BYTES),
   localparam int POS_W      = $clog2(MAX_SYM + 1) + 1,
   localparam int CNT_W      = $clog2(MAX_ERR + 1) + 1,
   localparam int IDX_W      = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start_i,
   input  logic [CNT_W-1:0]         err_cnt_i,
   input  logic [MAX_ERR*POS_W-1:0] err_pos_i,
   input  logic [MAX_ERR*SYM_W-1:0] err_pat_i,
   input  logic [7:0]               buf_rdata_i,
   output logic [ADDR_W-1:0]        buf_addr_o,
   output logic                     buf_rd_o,
   output logic                     buf_wr_o,
   output logic [7:0]               buf_wdata_o,
   output logic                     done_o,
   output logic                     fail_o,
   output logic [CNT_W-1:0]         count_o
);

   if (SYM_W != 12) begin : g_err_sym
      $error("symfix_apply: the packing rule needs 12-bit symbols");
   end
   if ((MAX_SYM * 3) / 2 + 1 >= BUF_BYTES) begin : g_err_range
      $error("symfix_apply: highest symbol exceeds the buffer");
   end
   if (ADDR_W > POS_W + 1) begin : g_err_addr
      $error("symfix_apply: address wider than the mapped offset");
   end

   logic [MAX_ERR*POS_W-1:0]  lat_pos;
   logic [MAX_ERR*SYM_W-1:0]  lat_pat;
   logic [CNT_W-1:0]          lat_cnt;
   logic [MAX_ERR*ADDR_W-1:0] m_addr0;
   logic [MAX_ERR*ADDR_W-1:0] m_addr1;
   logic [MAX_ERR*8-1:0]      m_mask0;
   logic [MAX_ERR*8-1:0]      m_mask1;
   logic [MAX_ERR-1:0]        m_pair;
   logic [MAX_ERR-1:0]        m_ok;
   logic                      list_bad;

   for (genvar i = 0; i < MAX_ERR; i++) begin : g_map
      symfix_map #(
         .POS_W  (POS_W),
         .SYM_W  (SYM_W),
         .ADDR_W (ADDR_W),
         .MAX_SYM(MAX_SYM)
      ) u_map (
         .pos_i  (lat_pos[i*POS_W +: POS_W]),
         .pat_i  (lat_pat[i*SYM_W +: SYM_W]),
         .addr0_o(m_addr0[i*ADDR_W +: ADDR_W]),
         .mask0_o(m_mask0[i*8 +: 8]),
         .addr1_o(m_addr1[i*ADDR_W +: ADDR_W]),
         .mask1_o(m_mask1[i*8 +: 8]),
         .pair_o (m_pair[i]),
         .ok_o   (m_ok[i])
      );
   end

   symfix_screen #(
      .MAX_ERR(MAX_ERR),
      .CNT_W  (CNT_W)
   ) u_screen (
      .ok_i (m_ok),
      .cnt_i(lat_cnt),
      .bad_o(list_bad)
   );

   symfix_seq #(
      .MAX_ERR(MAX_ERR),
      .POS_W  (POS_W),
      .SYM_W  (SYM_W),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start_i),
      .cnt_i     (err_cnt_i),
      .pos_i     (err_pos_i),
      .pat_i     (err_pat_i),
      .lat_pos_o (lat_pos),
      .lat_pat_o (lat_pat),
      .lat_cnt_o (lat_cnt),
      .m_addr0_i (m_addr0),
      .m_mask0_i (m_mask0),
      .m_addr1_i (m_addr1),
      .m_mask1_i (m_mask1),
      .m_pair_i  (m_pair),
      .bad_i     (list_bad),
      .rdata_i   (buf_rdata_i),
      .buf_addr_o(buf_addr_o),
      .rd_o      (buf_rd_o),
      .wr_o      (buf_wr_o),
      .wdata_o   (buf_wdata_o),
      .done_o    (done_o),
      .fail_o    (fail_o),
      .count_o   (count_o)
   );

   // R6: every access stays inside data plus spare bytes
   a_r6_addr_in_buffer: assert property (@(posedge clk) disable iff (rst)
      (buf_rd_o || buf_wr_o) |-> ({1'b0, buf_addr_o} < (ADDR_W+1)'(BUF_BYTES)));

endmodule

// File: tb/test_symfix_apply.sv
module test_symfix_apply;

   localparam int NBYTES = 2112;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [3:0]  err_cnt = '0;
   logic [47:0] err_pos = '0;
   logic [47:0] err_pat = '0;
   logic [7:0]  rdata = '0;
   logic [11:0] addr;
   logic        rd, wr, done, fail;
   logic [7:0]  wdata;
   logic [3:0]  count;

   logic [7:0] buf_mem [0:NBYTES-1];
   logic [7:0] ref_mem [0:NBYTES-1];

   int vectors = 0;
   int miscompares = 0;
   int jp [4];
   int jq [4];
   int ek [$];
   int ea [$];
   int em [$];
   int xf, xc;

   always #10 clk = ~clk;

   symfix_apply i_symfix_apply (
      .clk(clk), .rst(rst), .start_i(start), .err_cnt_i(err_cnt),
      .err_pos_i(err_pos), .err_pat_i(err_pat), .buf_rdata_i(rdata),
      .buf_addr_o(addr), .buf_rd_o(rd), .buf_wr_o(wr), .buf_wdata_o(wdata),
      .done_o(done), .fail_o(fail), .count_o(count)
   );

   // single-port buffer, one-cycle read latency
   always @(posedge clk) begin
      if (rd) rdata <= buf_mem[addr];
      if (wr) buf_mem[addr] <= wdata;
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   task automatic push_op(input int a, input int m);
      ek.push_back(1); ea.push_back(a); em.push_back(0);
      ek.push_back(2); ea.push_back(a); em.push_back(m & 255);
   endtask

   task automatic check_cycle(input string tag, input int k);
      int xw;
      vectors++;
      case (ek[k])
         0: if (rd || wr || done) begin
               miscompares++;
               $display("FAIL %s/R11 cycle %0d idle: rd=%0b wr=%0b done=%0b expected 0 0 0",
                        tag, k, rd, wr, done);
            end
         1: if (!rd || wr || done || addr != ea[k]) begin
               miscompares++;
               $display("FAIL %s/R10 cycle %0d read: rd=%0b wr=%0b addr=%0d expected rd=1 wr=0 addr=%0d",
                        tag, k, rd, wr, addr, ea[k]);
            end
         2: begin
               xw = ref_mem[ea[k]] ^ em[k];
               if (rd || !wr || done || addr != ea[k] || wdata != xw[7:0]) begin
                  miscompares++;
                  $display("FAIL %s/R10 cycle %0d write: wr=%0b addr=%0d wdata=%02h expected wr=1 addr=%0d wdata=%02h",
                           tag, k, wr, addr, wdata, ea[k], xw[7:0]);
               end
               ref_mem[ea[k]] = xw[7:0];
            end
         default: if (!done || rd || wr || fail != xf[0] || count != xc) begin
               miscompares++;
               $display("FAIL %s/R11/R12 cycle %0d done: done=%0b fail=%0b count=%0d expected done=1 fail=%0d count=%0d",
                        tag, k, done, fail, count, xf, xc);
            end
      endcase
   endtask

   task automatic run_job(input string tag, input int n, input bit poke);
      int bad, h, bad_cnt, first;
      ek.delete(); ea.delete(); em.delete();
      bad = (n > 4) ? 1 : 0;
      for (int i = 0; i < 4 && i < n; i++)
         if (jp[i] > 1374 || (jp[i] == 0 && jq[i] > 255)) bad = 1;
      ek.push_back(0); ea.push_back(0); em.push_back(0);
      if (bad == 0) begin
         for (int i = 0; i < n; i++) begin
            h = (3 * jp[i]) / 2;
            if (jp[i] == 0) push_op(0, jq[i]);
            else if (jp[i] % 2 == 1) begin
               push_op(h, jq[i] >> 4);
               push_op(h + 1, (jq[i] & 15) << 4);
            end else begin
               push_op(h - 1, jq[i] >> 8);
               push_op(h, jq[i]);
            end
         end
      end
      ek.push_back(3); ea.push_back(0); em.push_back(0);
      ek.push_back(0); ea.push_back(0); em.push_back(0);
      xf = bad;
      xc = (bad != 0) ? 0 : n;
      start   = 1'b1;
      err_cnt = 4'(n);
      for (int i = 0; i < 4; i++) begin
         err_pos[i*12 +: 12] = 12'(jp[i]);
         err_pat[i*12 +: 12] = 12'(jq[i]);
      end
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < ek.size(); k++) begin
         check_cycle(tag, k);
         if (poke && k == 1) begin
            start = 1'b1;
            err_cnt = 4'd1;
            err_pos = '0;
            err_pat = 48'h0FF;
         end else start = 1'b0;
         @(negedge clk);
      end
      vectors++;
      bad_cnt = 0;
      first = 0;
      for (int a = 0; a < NBYTES; a++)
         if (buf_mem[a] !== ref_mem[a]) begin
            if (bad_cnt == 0) first = a;
            bad_cnt++;
         end
      if (bad_cnt != 0) begin
         miscompares++;
         $display("FAIL %s/R8 buffer image: byte %0d is %02h expected %02h (%0d bytes differ)",
                  tag, first, buf_mem[first], ref_mem[first], bad_cnt);
      end
   endtask

   task automatic set4(input int p0, input int q0, input int p1, input int q1,
                       input int p2, input int q2, input int p3, input int q3);
      jp[0] = p0; jq[0] = q0; jp[1] = p1; jq[1] = q1;
      jp[2] = p2; jq[2] = q2; jp[3] = p3; jq[3] = q3;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int a = 0; a < NBYTES; a++) begin
         buf_mem[a] = 8'((a * 73 + 11) & 255);
         ref_mem[a] = 8'((a * 73 + 11) & 255);
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      vectors++;
      if (rd || wr || done || fail || count != 0) begin
         miscompares++;
         $display("FAIL R11 reset: rd=%0b wr=%0b done=%0b fail=%0b count=%0d expected all 0",
                  rd, wr, done, fail, count);
      end
      set4(0, 'h0A5, 0, 0, 0, 0, 0, 0);          run_job("R1", 1, 0);
      set4(0, 'h1A5, 0, 0, 0, 0, 0, 0);          run_job("R2", 1, 0);
      set4(7, 'hABC, 0, 0, 0, 0, 0, 0);          run_job("R3", 1, 0);
      set4(8, 'hABC, 0, 0, 0, 0, 0, 0);          run_job("R4", 1, 0);
      set4(1365, 'h5A3, 0, 0, 0, 0, 0, 0);       run_job("R5", 1, 0);
      set4(1366, 'h9E1, 1374, 'h37F, 1373, 'h111, 0, 0); run_job("R6", 3, 0);
      set4(1375, 'h001, 0, 0, 0, 0, 0, 0);       run_job("R7", 1, 0);
      set4(3, 'h123, 1400, 'h456, 9, 'h789, 0, 0); run_job("R8", 3, 0);
      set4(4, 'hF0F, 6, 'h0F0, 2000, 'hFFF, 0, 'hFFF); run_job("R8", 2, 0);
      set4(1, 'h111, 2, 'h222, 3, 'h333, 4, 'h444); run_job("R9", 5, 0);
      set4(1, 'hC3A, 2, 'h5D7, 0, 'h0EE, 1374, 'hB42); run_job("R10", 4, 0);
      set4(5, 'hFFF, 6, 'hFFF, 7, 'hFFF, 8, 'hFFF); run_job("R11", 0, 0);
      set4(10, 'h6B9, 11, 'h2C4, 0, 0, 0, 0);    run_job("R13", 2, 1);
      set4(1, 'hFFF, 1365, 'hFFF, 1370, 'h800, 1371, 'h001); run_job("R12", 4, 0);
      finish_run();
   end

endmodule